// File: doc/BRIEF.md
# Transport Packet Aligner and Derandomizer

This block takes a stream of coded transport packets, 204 bytes each, one byte per cycle that carries `in_valid`. It finds the packet boundary from the sync byte (plain 0x47 or inverted 0xB8). It confirms that boundary at a fixed 204-byte pitch and holds lock with hysteresis. Once locked, it undoes the energy-dispersal scrambling of the 188-byte data region with a 15-bit pseudo-random sequence. That sequence restarts on every inverted sync byte.

The 16 trailing parity bytes of each packet leave unchanged and are flagged, so that a later error-correction stage can use them. A separate eight-packet flywheel predicts where the next inverted sync byte should appear. It raises a derandomizer-sync flag when that prediction is met. The flywheel keeps restarting the sequence at the predicted packet even when the inverted byte is missing. Every input byte appears on the output one clock later, with a start-of-packet marker and the two lock flags.

Top module: `tsp_sync_descramble`

## Requirements
- R1: Hunting starts on any 0x47 or 0xB8 byte, which becomes packet position 0. A sync byte (0x47 or 0xB8) at position 0 of each of the next two packets, 204 valid bytes apart, sets `pkt_lock`. The flag is already high on the output cycle that carries that third sync byte.
- R2: While lock is being confirmed, a non-sync byte at position 0 abandons the candidate and hunting resumes; `pkt_lock` stays low.
- R3: While locked, one or two consecutive non-sync bytes at position 0 keep `pkt_lock` high. The third consecutive one clears it, and that byte leaves unmodified with `out_sop` low. A good sync byte clears the miss count.
- R4: Each valid input byte leaves on `out_byte` exactly one clock later with `out_valid` high. `out_valid` is low one clock after an idle cycle, and idle cycles do not advance the packet position or the sequence.
- R5: While unlocked, bytes pass unchanged, and `out_sop`, `out_parity` and `rnd_sync` are low.
- R6: While locked, `out_sop` marks the byte at position 0. An incoming 0xB8 there leaves as 0x47, and any other value leaves unchanged.
- R7: The sequence register r1..r15 has taps r14 and r15 (generator 1 + x^14 + x^15). Each step outputs r14 XOR r15 and shifts that bit into r1. The register is seeded with r1..r15 = 100101010000000. Bytes at positions 1 to 187 are XORed with the next 8 output bits, the first bit into the byte's MSB.
- R8: A 0xB8 at position 0 reloads the seed, so the next data byte uses the first 8 bits from the seed. At position 0 of a packet with no reload, the sequence advances 8 bits without being applied.
- R9: Bytes at positions 188 to 203 leave unchanged with `out_parity` high, and the sequence does not advance during them.
- R10: A packet counter modulo 8 marks a predicted group head. A 0xB8 at a predicted head sets `rnd_sync`. Any other byte at a predicted head clears `rnd_sync`. A 0xB8 elsewhere clears `rnd_sync` and realigns the counter so that this packet becomes the head. Loss of packet lock clears `rnd_sync`.
- R11: At a predicted group head the seed is reloaded even when the byte is not 0xB8.
- R12: After reset all outputs are low and the first locked packet is a predicted group head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Coded packet byte |
| out_valid | output | 1 | Output byte strobe |
| out_byte | output | 8 | Derandomized byte |
| out_sop | output | 1 | Position 0 of a locked packet |
| out_parity | output | 1 | Parity byte of a locked packet |
| pkt_lock | output | 1 | Packet boundary lock |
| rnd_sync | output | 1 | Inverted sync seen at predicted group head |

## Verification
The stream opens with sync-free bytes, then packets whose inverted sync bytes begin off the flywheel's first guess. This separates realignment from a true group match and shows a reload by prediction on a plain sync byte. Isolated and triple corrupted sync bytes tell lock hysteresis apart from loss. A candidate that is followed by a miss shows that confirmation is abandoned. Idle gaps inside packets show that the position and the sequence are gated by the strobe.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

  typedef enum logic [1:0] {ST_HUNT, ST_VERIFY, ST_LOCK} sync_state_e;

  localparam int PRBS_W = 15;
  typedef logic [PRBS_W-1:0] prbs_t;

  // s[0] holds r1, s[14] holds r15; output bit is r14 ^ r15
  function automatic logic [7:0] prbs_key8(input prbs_t s);
    prbs_t      t;
    logic       fb;
    logic [7:0] k;
    t = s;
    k = '0;
    for (int i = 0; i < 8; i++) begin
      fb       = t[13] ^ t[14];
      k[7-i]   = fb;
      t        = {t[13:0], fb};
    end
    return k;
  endfunction

  function automatic prbs_t prbs_next8(input prbs_t s);
    prbs_t t;
    logic  fb;
    t = s;
    for (int i = 0; i < 8; i++) begin
      fb = t[13] ^ t[14];
      t  = {t[13:0], fb};
    end
    return t;
  endfunction

endpackage

// File: rtl/tsd_framer.sv
module tsd_framer
  import tsd_pkg::*;
#(
  parameter int          PKT_LEN    = 204,
  parameter logic [7:0]  SYNC_BYTE  = 8'h47,
  parameter logic [7:0]  SYNC_INV   = 8'hB8,
  parameter int          HIT_COUNT  = 3,
  parameter int          MISS_COUNT = 3,
  localparam int         POS_W      = $clog2(PKT_LEN),
  localparam int         CNT_MAX    = (HIT_COUNT > MISS_COUNT) ? HIT_COUNT : MISS_COUNT,
  localparam int         CNT_W      = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             frame_on,
  output logic [POS_W-1:0] pos,
  output logic             locked
);

  sync_state_e      state_q, state_n;
  logic [POS_W-1:0] pos_q, pos_n, pos_inc;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             is_sync, at_head;

  assign is_sync = (in_byte == SYNC_BYTE) || (in_byte == SYNC_INV);
  assign at_head = (pos_q == '0);
  assign pos_inc = (pos_q == POS_W'(PKT_LEN - 1)) ? '0 : pos_q + 1'b1;

  always_comb begin
    state_n = state_q;
    pos_n   = pos_q;
    cnt_n   = cnt_q;
    if (in_valid) begin
      unique case (state_q)
        ST_HUNT: begin
          if (is_sync) begin
            state_n = ST_VERIFY;
            cnt_n   = CNT_W'(1);
            pos_n   = POS_W'(1);
          end
        end
        ST_VERIFY: begin
          pos_n = pos_inc;
          if (at_head) begin
            if (is_sync) begin
              if (cnt_q == CNT_W'(HIT_COUNT - 1)) begin
                state_n = ST_LOCK;
                cnt_n   = '0;
              end else begin
                cnt_n = cnt_q + 1'b1;
              end
            end else begin
              state_n = ST_HUNT;
              cnt_n   = '0;
              pos_n   = '0;
            end
          end
        end
        ST_LOCK: begin
          pos_n = pos_inc;
          if (at_head) begin
            if (is_sync) begin
              cnt_n = '0;
            end else if (cnt_q == CNT_W'(MISS_COUNT - 1)) begin
              state_n = ST_HUNT;
              cnt_n   = '0;
              pos_n   = '0;
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        default: begin
          state_n = ST_HUNT;
          cnt_n   = '0;
          pos_n   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HUNT;
      pos_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      pos_q   <= pos_n;
      cnt_q   <= cnt_n;
    end
  end

  assign frame_on = in_valid && (state_n == ST_LOCK);
  assign pos      = pos_q;
  assign locked   = (state_q == ST_LOCK);

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    pos_q < POS_W'(PKT_LEN)); // R1

  AST_LOCK_ON_SYNC: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(in_valid && at_head && is_sync)); // R1

  AST_UNLOCK_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(in_valid && at_head && !is_sync)); // R3

  AST_IDLE_HOLDS_POS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(pos_q) && $stable(state_q)); // R4

endmodule

// File: rtl/tsd_derand.sv
module tsd_derand
  import tsd_pkg::*;
#(
  parameter int          PKT_LEN   = 204,
  parameter int          DATA_LEN  = 188,
  parameter int          GROUP     = 8,
  parameter logic [7:0]  SYNC_BYTE = 8'h47,
  parameter logic [7:0]  SYNC_INV  = 8'hB8,
  parameter logic [14:0] SEED      = 15'h00A9,
  localparam int         POS_W     = $clog2(PKT_LEN),
  localparam int         GRP_W     = $clog2(GROUP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             frame_on,
  input  logic [POS_W-1:0] pos,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             out_sop,
  output logic             out_parity,
  output logic             rnd_sync
);

  prbs_t            prbs_q;
  logic [GRP_W-1:0] grp_q, grp_inc;
  logic             at_head, in_data, head_inv, pred_head, reload;

  assign at_head   = (pos == '0);
  assign in_data   = (pos < POS_W'(DATA_LEN));
  assign head_inv  = (in_byte == SYNC_INV);
  assign pred_head = (grp_q == '0);
  assign reload    = head_inv || pred_head;
  assign grp_inc   = (grp_q == GRP_W'(GROUP - 1)) ? '0 : grp_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      prbs_q     <= SEED;
      grp_q      <= '0;
      out_valid  <= 1'b0;
      out_byte   <= '0;
      out_sop    <= 1'b0;
      out_parity <= 1'b0;
      rnd_sync   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        if (!frame_on) begin
          out_byte   <= in_byte;
          out_sop    <= 1'b0;
          out_parity <= 1'b0;
          rnd_sync   <= 1'b0;
        end else if (at_head) begin
          out_byte   <= head_inv ? SYNC_BYTE : in_byte;
          out_sop    <= 1'b1;
          out_parity <= 1'b0;
          prbs_q     <= reload ? SEED : prbs_next8(prbs_q);
          if (head_inv) begin
            rnd_sync <= pred_head;
            grp_q    <= GRP_W'(1);
          end else begin
            if (pred_head) rnd_sync <= 1'b0;
            grp_q <= grp_inc;
          end
        end else if (in_data) begin
          out_byte   <= in_byte ^ prbs_key8(prbs_q);
          out_sop    <= 1'b0;
          out_parity <= 1'b0;
          prbs_q     <= prbs_next8(prbs_q);
        end else begin
          out_byte   <= in_byte;
          out_sop    <= 1'b0;
          out_parity <= 1'b1;
        end
      end
    end
  end

  AST_PARITY_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && frame_on && !in_data) |=> $stable(prbs_q)); // R9

  AST_SEED_ON_INV: assert property (@(posedge clk) disable iff (rst)
    (in_valid && frame_on && at_head && head_inv) |=> (prbs_q == SEED)); // R8

  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(prbs_q) && $stable(grp_q)); // R4

  AST_UNLOCKED_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !frame_on) |=> $stable(prbs_q) && !rnd_sync); // R5

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(out_sop && out_parity)); // R9

endmodule

// File: rtl/tsp_sync_descramble.sv
module tsp_sync_descramble #(
  parameter int          PKT_LEN    = 204,
  parameter int          DATA_LEN   = 188,
  parameter int          GROUP      = 8,
  parameter int          HIT_COUNT  = 3,
  parameter int          MISS_COUNT = 3,
  parameter logic [7:0]  SYNC_BYTE  = 8'h47,
  parameter logic [7:0]  SYNC_INV   = 8'hB8,
  parameter logic [14:0] SEED       = 15'h00A9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  output logic [7:0] out_byte,
  output logic       out_sop,
  output logic       out_parity,
  output logic       pkt_lock,
  output logic       rnd_sync
);

  localparam int POS_W = $clog2(PKT_LEN);

  logic             frame_on;
  logic [POS_W-1:0] pos;

  tsd_framer #(
    .PKT_LEN   (PKT_LEN),
    .SYNC_BYTE (SYNC_BYTE),
    .SYNC_INV  (SYNC_INV),
    .HIT_COUNT (HIT_COUNT),
    .MISS_COUNT(MISS_COUNT)
  ) i_framer (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .in_byte (in_byte),
    .frame_on(frame_on),
    .pos     (pos),
    .locked  (pkt_lock)
  );

  tsd_derand #(
    .PKT_LEN  (PKT_LEN),
    .DATA_LEN (DATA_LEN),
    .GROUP    (GROUP),
    .SYNC_BYTE(SYNC_BYTE),
    .SYNC_INV (SYNC_INV),
    .SEED     (SEED)
  ) i_derand (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .frame_on  (frame_on),
    .pos       (pos),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .out_sop   (out_sop),
    .out_parity(out_parity),
    .rnd_sync  (rnd_sync)
  );

  AST_RSYNC_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    rnd_sync |-> pkt_lock); // R10

  AST_SOP_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    out_sop |-> pkt_lock); // R6

endmodule

// File: tb/test_tsp_sync_descramble.sv
module test_tsp_sync_descramble;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_valid, out_sop, out_parity, pkt_lock, rnd_sync;
  logic [7:0] out_byte;

  always #10 clk = ~clk; // 50 MHz

  tsp_sync_descramble i_tsp_sync_descramble (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_byte(out_byte), .out_sop(out_sop),
    .out_parity(out_parity), .pkt_lock(pkt_lock), .rnd_sync(rnd_sync)
  );

  typedef struct {
    logic [7:0] b;
    bit         sop, par, lk, rs;
    string      tag, ltag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;

  // reference state, written from the requirements
  int       m_state = 0; // 0 hunt, 1 confirm, 2 locked
  int       m_pos = 0, m_cnt = 0, m_grp = 0;
  bit       m_rs = 0, m_fly = 0, m_inv = 0;
  bit [1:15] m_r = 15'b100101010000000;
  localparam bit [1:15] SEEDR = 15'b100101010000000;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [7:0] keybyte(inout bit [1:15] r);
    bit [7:0] k;
    bit fb;
    for (int j = 0; j < 8; j++) begin
      fb = r[14] ^ r[15];
      k[7-j] = fb;
      r = {fb, r[1:14]};
    end
    return k;
  endfunction

  task automatic model(input bit [7:0] b, output exp_t e);
    bit sy = (b == 8'h47) || (b == 8'hB8);
    int pc = m_pos;
    bit lk;
    bit [7:0] dummy;
    e.ltag = "R1";
    if (m_state == 0) begin
      if (sy) begin m_state = 1; m_cnt = 1; m_pos = 1; end
    end else begin
      m_pos = (m_pos == 203) ? 0 : m_pos + 1;
      if (pc == 0) begin
        if (m_state == 1) begin
          if (sy) begin
            if (m_cnt == 2) begin m_state = 2; m_cnt = 0; end else m_cnt++;
          end else begin m_state = 0; m_cnt = 0; m_pos = 0; e.ltag = "R2"; end
        end else begin
          if (sy) m_cnt = 0;
          else begin
            e.ltag = "R3";
            if (m_cnt == 2) begin m_state = 0; m_cnt = 0; m_pos = 0; end else m_cnt++;
          end
        end
      end
    end
    lk = (m_state == 2);
    e.lk = lk; e.sop = 0; e.par = 0;
    if (!lk) begin
      e.b = b; m_rs = 0; e.tag = (e.ltag == "R3") ? "R3" : "R5";
    end else if (pc == 0) begin
      bit head;
      e.sop = 1;
      e.b = (b == 8'hB8) ? 8'h47 : b;
      e.tag = "R6";
      if (b == 8'hB8) begin
        head = 1; m_rs = (m_grp == 0); m_grp = 1; m_inv = 1; m_fly = 0;
      end else begin
        head = (m_grp == 0);
        if (head) m_rs = 0;
        m_fly = head; m_inv = 0;
        m_grp = (m_grp + 1) % 8;
        if (head) e.tag = "R11";
      end
      if (head) m_r = SEEDR;
      else dummy = keybyte(m_r);
    end else if (pc < 188) begin
      e.b = b ^ keybyte(m_r);
      e.tag = m_fly ? "R11" : (m_inv ? "R8" : "R7");
    end else begin
      e.b = b; e.par = 1; e.tag = "R9";
    end
    e.rs = m_rs;
  endtask

  task automatic send(input bit [7:0] b);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    model(b, e);
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_byte  = 8'h5A;
    end
  endtask

  task automatic send_pkt(input int seq, input bit [7:0] head);
    for (int i = 0; i < 204; i++) begin
      bit [7:0] b;
      b = (i == 0) ? head : 8'((seq * 31 + i * 13 + 5) & 255);
      if (i != 0 && (b == 8'h47 || b == 8'hB8)) b = b ^ 8'h01;
      send(b);
      if ((seq % 5 == 1) && (i == 100 || i == 195)) idle(2);
    end
  endtask

  // monitor: pops expectations as outputs appear
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q.size() == 0) begin
        chk("R4 unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " out_byte"}, out_byte, e.b);
        chk("R6 out_sop", out_sop, e.sop);
        chk("R9 out_parity", out_parity, e.par);
        chk({e.ltag, " pkt_lock"}, pkt_lock, e.lk);
        chk("R10 rnd_sync", rnd_sync, m_rs_hist(e));
      end
    end
  end

  function automatic int m_rs_hist(input exp_t e);
    return e.rs;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R4 watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: outputs low after reset
    chk("R12 out_valid", out_valid, 0);
    chk("R12 out_sop", out_sop, 0);
    chk("R12 out_parity", out_parity, 0);
    chk("R12 pkt_lock", pkt_lock, 0);
    chk("R12 rnd_sync", rnd_sync, 0);

    // R5: sync-free bytes while unlocked
    for (int i = 0; i < 30; i++) send(8'(i * 3 + 1));
    idle(3);

    // R1/R8/R10/R11: lock, flywheel reload, realignment, group match
    for (int p = 0; p < 20; p++) send_pkt(p, (p % 8 == 0) ? 8'hB8 : 8'h47);
    // R3: two misses keep lock
    send_pkt(20, 8'h00);
    send_pkt(21, 8'h11);
    send_pkt(22, 8'h47);
    idle(1);
    chk("R3 lock held after two misses", pkt_lock, 1);
    send_pkt(23, 8'h47);
    // R11/R10: predicted head without inverted byte
    send_pkt(24, 8'h47);
    for (int p = 25; p < 32; p++) send_pkt(p, 8'h47);
    send_pkt(32, 8'hB8);
    // R3: three misses drop lock
    send_pkt(33, 8'h00);
    send_pkt(34, 8'h01);
    send_pkt(35, 8'h02);
    idle(1);
    chk("R3 lock lost after three misses", pkt_lock, 0);
    // R2: candidate then miss
    send_pkt(36, 8'h47);
    send_pkt(37, 8'h03);
    idle(1);
    chk("R2 candidate abandoned", pkt_lock, 0);
    // R1: relock
    send_pkt(38, 8'hB8);
    send_pkt(39, 8'h47);
    send_pkt(40, 8'h47);
    idle(1);
    chk("R1 relocked", pkt_lock, 1);
    for (int p = 41; p < 47; p++) send_pkt(p, (p == 46) ? 8'hB8 : 8'h47);
    idle(4);
    chk("R4 all bytes delivered", q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule